// File: doc/BRIEF.md
# Parallel-Port Card Bus Target (Configuration and I/O)

This block is the 32-bit bus-side target of a single-function parallel-port adapter. It watches the shared multiplexed address/data bus. In the address phase it captures the address and command. It decides whether the access belongs to it, and claims it by driving the active-low device-select line. It then completes data phases with its ready line, paced by the initiator's ready line. It holds a type-0 configuration header: identity words, a command word, a class code for a parallel port, two I/O base registers and the interrupt fields. Each of the two 8-byte I/O windows becomes its own chip select toward the downstream port register file.

Reads return data on the bus. The even-parity bit for that data follows one clock later. Bursts are supported: the block steps its own address by one dword after every completed data phase. Header defaults are parameters.

The state machine has three states:
- `ST_IDLE` waits for the falling edge of the frame line.
- `ST_DATA` means the access is claimed.
- `ST_SKIP` means the access belongs to another agent.

The transitions are:
- `ST_IDLE` to `ST_DATA`, on an address phase that decodes as a hit.
- `ST_IDLE` to `ST_SKIP`, on an address phase that misses.
- `ST_DATA` to `ST_IDLE`, on a completed phase while frame is high (the final transfer).
- `ST_SKIP` to `ST_IDLE`, once frame and initiator-ready are both high (bus idle).

Top module: `pci_io_target`

## Requirements
- R1: Reset state. During and after reset, with no access, `devsel_n` and `trdy_n` are 1, `ad_oe` and `par_oe` are 0, and `lcl_sel` is 0.
- R2: Configuration access timing. A configuration read (command 1010) or write (command 1011) with `idsel` high, `ad_in[1:0]`=00 and `ad_in[10:8]`=000 in the address phase is claimed. `devsel_n` and `trdy_n` go low in the cycle after the address phase, and a read drives the addressed header dword on `ad_out`.
- R2 (header contents): dword 00h reads {device ID, vendor ID}. Dword 04h reads 0 except bit 0, the I/O enable. Dword 08h reads {class 070102h, revision 01h}. Dword 2Ch reads {subsystem ID, subsystem vendor ID}. Dword 3Ch reads {16'h0, interrupt pin 01h, interrupt line}.
- R3: A configuration command with `idsel` low, or with a nonzero function number in `ad_in[10:8]`, is never claimed.
- R4: Dwords 10h and 14h are I/O base registers. Bits 2:1 read 0 and bit 0 reads 1, so writing all ones reads back FFFFFFF9h. The upper bits read back as written.
- R5: I/O read (0010) and I/O write (0011) commands are claimed only while header bit 04h[0] is 1. Memory commands (0110, 0111) are never claimed.
- R6: An I/O access whose address bits 31:3 match base register 10h sets `lcl_sel`=01; a match with 14h sets `lcl_sel`=10. On each completed write phase, `lcl_wr` pulses with `lcl_addr`=address[2:0], `lcl_wdata`=`ad_in` and `lcl_be`=~`cbe_n`.
- R7: During a claimed I/O read, `ad_out` carries `lcl_rdata`. `lcl_rd` pulses on the completed phase.
- R8: A cycle in the data state with `irdy_n` high is a wait state. No local strobe fires and no header write happens in it.
- R9: In a burst, the address used by each data phase is 4 more than the one before.
- R10: After the phase completed with `frame_n` high, `devsel_n` and `trdy_n` return to 1 on the next cycle.
- R11: One clock after every cycle in which `ad_oe` is 1, `par_oe` is 1. `par_out` then equals the XOR of the previous cycle's `ad_out` and `cbe_n`, which makes even parity over the 36 bits.
- R12: Configuration writes update only the bytes whose `cbe_n` bit is 0. Dwords without writable fields are unaffected.
- R13: Reserved header dwords (0Ch, 18h to 28h, 30h to 38h) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | Command (address phase) / byte enables, active low |
| ad_in | input | 32 | Address/data bus as seen by the block |
| ad_out | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Enable for `ad_out` |
| par_out | output | 1 | Even parity for the previous read cycle |
| par_oe | output | 1 | Enable for `par_out` |
| devsel_n | output | 1 | Claim indication, active low |
| trdy_n | output | 1 | Target ready, active low |
| lcl_sel | output | 2 | One-hot I/O window select |
| lcl_addr | output | 3 | Byte offset within the window |
| lcl_be | output | 4 | Active-high byte enables |
| lcl_wdata | output | 32 | Write data toward the register file |
| lcl_wr | output | 1 | Local write strobe |
| lcl_rd | output | 1 | Local read strobe |
| lcl_rdata | input | 32 | Read data from the register file |

## Verification
The hardest condition to reach from the ports is a wait state inside a claimed burst that crosses from one window dword to the next. The wait shows whether the address counter steps only on completed phases. It also shows whether local strobes hold off while the device select stays asserted.

Reaching it needs a setup sequence. The base registers are first programmed through a two-phase configuration burst, and I/O decode is switched on by a byte-masked header write. Only then do I/O bursts run, with the initiator holding its ready line off in the first data cycle.

A per-cycle model in the bench predicts the bus outputs and parity for every clock and checks them. This includes unclaimed traffic, which must leave every output quiet.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_SKIP = 2'd2
    } tgt_state_e;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int          BUS_W     = 32;
    localparam int          BE_W      = BUS_W / 8;
    localparam logic [31:0] ADDR_STEP = 32'd4;

    localparam logic [5:0] DW_ID      = 6'd0;
    localparam logic [5:0] DW_CMDSTAT = 6'd1;
    localparam logic [5:0] DW_CLASS   = 6'd2;
    localparam logic [5:0] DW_BAR0    = 6'd4;
    localparam logic [5:0] DW_SUBSYS  = 6'd11;
    localparam logic [5:0] DW_INTR    = 6'd15;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int WIN_BITS = 3
) (
    input  logic [31:0]              ad_in,
    input  logic [3:0]               cmd,
    input  logic                     idsel,
    input  logic                     io_en,
    input  logic [NUM_WIN-1:0][31:0] bar_base,
    output logic                     hit,
    output logic                     is_cfg,
    output logic                     is_wr,
    output logic [NUM_WIN-1:0]       win
);
    localparam logic [31:0] LOW_MASK = (32'd1 << WIN_BITS) - 32'd1;

    logic                io_cmd;
    logic [NUM_WIN-1:0]  raw_match;

    assign io_cmd = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
    assign is_cfg = ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR))
                    && idsel && (ad_in[1:0] == 2'b00) && (ad_in[10:8] == 3'b000);
    assign is_wr  = cmd[0];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        assign raw_match[i] = io_cmd && io_en
                              && ((ad_in & ~LOW_MASK) == bar_base[i]);
    end

    // lowest-numbered window wins when two bases overlap
    always_comb begin
        win = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (raw_match[i]) begin
                win = '0;
                win[i] = 1'b1;
            end
        end
    end

    assign hit = is_cfg || (|win);

endmodule

// File: rtl/pci_tgt_cfg.sv
module pci_tgt_cfg
    import pci_tgt_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1E0F,
    parameter logic [15:0] DEVICE_ID  = 16'h0210,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [23:0] CLASS_CODE = 24'h070102,
    parameter logic [15:0] SUBSYS_VID = 16'h1E0F,
    parameter logic [15:0] SUBSYS_ID  = 16'h0001,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter int          NUM_WIN    = 2,
    parameter int          WIN_BITS   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [5:0]               dw_idx,
    input  logic [31:0]              wdata,
    input  logic [3:0]               be_n,
    output logic [31:0]              rdata,
    output logic                     io_en,
    output logic [NUM_WIN-1:0][31:0] bar_base
);
    localparam logic [31:0] LOW_MASK = (32'd1 << WIN_BITS) - 32'd1;

    logic       io_en_q;
    logic [7:0] int_line_q;
    logic [31:0] bar_rd [NUM_WIN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_en_q    <= 1'b0;
            int_line_q <= 8'h00;
        end else if (wr_en && !be_n[0]) begin
            if (dw_idx == DW_CMDSTAT) io_en_q    <= wdata[0];
            if (dw_idx == DW_INTR)    int_line_q <= wdata[7:0];
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_bar
        logic [31:0] bar_q;
        logic [31:0] merged;
        always_comb begin
            merged = bar_q;
            for (int b = 0; b < BE_W; b++) begin
                if (!be_n[b]) merged[8*b +: 8] = wdata[8*b +: 8];
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    bar_q <= '0;
            else if (wr_en && dw_idx == DW_BAR0 + 6'(i))   bar_q <= merged & ~LOW_MASK;
        end
        assign bar_base[i] = bar_q;
        assign bar_rd[i]   = bar_q | 32'd1;
    end

    always_comb begin
        rdata = '0;
        unique case (dw_idx)
            DW_ID:      rdata = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTAT: rdata = {31'd0, io_en_q};
            DW_CLASS:   rdata = {CLASS_CODE, REV_ID};
            DW_SUBSYS:  rdata = {SUBSYS_ID, SUBSYS_VID};
            DW_INTR:    rdata = {16'h0000, INT_PIN, int_line_q};
            default: begin
                for (int i = 0; i < NUM_WIN; i++) begin
                    if (dw_idx == DW_BAR0 + 6'(i)) rdata = bar_rd[i];
                end
            end
        endcase
    end

    assign io_en = io_en_q;

    a_r4_bar_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dw_idx == DW_BAR0) |=> ((bar_base[0] & LOW_MASK) == 32'd0));

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int WIN_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [31:0]         ad_in,
    input  logic                dec_hit,
    input  logic                dec_cfg,
    input  logic                dec_wr,
    input  logic [NUM_WIN-1:0]  dec_win,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                ad_oe,
    output logic                data_ph,
    output logic                xfer,
    output logic                cur_cfg,
    output logic                cur_wr,
    output logic [NUM_WIN-1:0]  cur_win,
    output logic [5:0]          cur_dw,
    output logic [WIN_BITS-1:0] cur_off
);
    tgt_state_e         state_q, state_d;
    logic [31:0]        addr_q;
    logic               cfg_q, wr_q;
    logic [NUM_WIN-1:0] win_q;
    logic               addr_ph;

    assign addr_ph = (state_q == ST_IDLE) && !frame_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!frame_n)           state_d = dec_hit ? ST_DATA : ST_SKIP;
            ST_DATA: if (!irdy_n && frame_n) state_d = ST_IDLE;
            ST_SKIP: if (frame_n && irdy_n)  state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        data_ph  = 1'b0;
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        ad_oe    = 1'b0;
        xfer     = 1'b0;
        unique case (state_q)
            ST_DATA: begin
                data_ph  = 1'b1;
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                ad_oe    = !wr_q;
                xfer     = !irdy_n;
            end
            ST_IDLE, ST_SKIP: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cfg_q  <= 1'b0;
            wr_q   <= 1'b0;
            win_q  <= '0;
        end else if (addr_ph) begin
            addr_q <= ad_in;
            cfg_q  <= dec_cfg;
            wr_q   <= dec_wr;
            win_q  <= dec_win;
        end else if (xfer) begin
            addr_q <= addr_q + ADDR_STEP;
        end
    end

    assign cur_cfg = cfg_q;
    assign cur_wr  = wr_q;
    assign cur_win = win_q;
    assign cur_dw  = addr_q[7:2];
    assign cur_off = addr_q[WIN_BITS-1:0];

    a_r9_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !irdy_n && !frame_n) |=> (addr_q == $past(addr_q) + ADDR_STEP));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !irdy_n && frame_n) |=> (devsel_n && trdy_n));

    a_r3_miss_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ph && !dec_hit) |=> devsel_n);

    a_r8_wait_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && irdy_n) |=> $stable(addr_q));

endmodule

// File: rtl/pci_tgt_par.sv
module pci_tgt_par
    import pci_tgt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            drive,
    input  logic [BUS_W-1:0] ad,
    input  logic [BE_W-1:0]  cbe_n,
    output logic            par_out,
    output logic            par_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_oe  <= drive;
            par_out <= drive ? ^{ad, cbe_n} : 1'b0;
        end
    end

    a_r11_par_on: assert property (@(posedge clk) disable iff (!rst_n)
        drive |=> par_oe);

    a_r11_par_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> !par_oe);

endmodule

// File: rtl/pci_io_target.sv
module pci_io_target
    import pci_tgt_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1E0F,
    parameter logic [15:0] DEVICE_ID  = 16'h0210,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [23:0] CLASS_CODE = 24'h070102,
    parameter logic [15:0] SUBSYS_VID = 16'h1E0F,
    parameter logic [15:0] SUBSYS_ID  = 16'h0001,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter int          NUM_WIN    = 2,
    parameter int          WIN_BITS   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic                idsel,
    input  logic [3:0]          cbe_n,
    input  logic [31:0]         ad_in,
    output logic [31:0]         ad_out,
    output logic                ad_oe,
    output logic                par_out,
    output logic                par_oe,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic [NUM_WIN-1:0]  lcl_sel,
    output logic [WIN_BITS-1:0] lcl_addr,
    output logic [3:0]          lcl_be,
    output logic [31:0]         lcl_wdata,
    output logic                lcl_wr,
    output logic                lcl_rd,
    input  logic [31:0]         lcl_rdata
);
    logic                     dec_hit, dec_cfg, dec_wr;
    logic [NUM_WIN-1:0]       dec_win;
    logic                     io_en;
    logic [NUM_WIN-1:0][31:0] bar_base;
    logic                     data_ph, xfer, cur_cfg, cur_wr;
    logic [NUM_WIN-1:0]       cur_win;
    logic [5:0]               cur_dw;
    logic [31:0]              cfg_rdata;

    pci_tgt_decode #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)) u_dec (
        .ad_in(ad_in), .cmd(cbe_n), .idsel(idsel), .io_en(io_en),
        .bar_base(bar_base), .hit(dec_hit), .is_cfg(dec_cfg),
        .is_wr(dec_wr), .win(dec_win)
    );

    pci_tgt_fsm #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .dec_hit(dec_hit), .dec_cfg(dec_cfg),
        .dec_wr(dec_wr), .dec_win(dec_win), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .ad_oe(ad_oe), .data_ph(data_ph), .xfer(xfer),
        .cur_cfg(cur_cfg), .cur_wr(cur_wr), .cur_win(cur_win),
        .cur_dw(cur_dw), .cur_off(lcl_addr)
    );

    pci_tgt_cfg #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
        .CLASS_CODE(CLASS_CODE), .SUBSYS_VID(SUBSYS_VID),
        .SUBSYS_ID(SUBSYS_ID), .INT_PIN(INT_PIN),
        .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(xfer && cur_cfg && cur_wr),
        .dw_idx(cur_dw), .wdata(ad_in), .be_n(cbe_n), .rdata(cfg_rdata),
        .io_en(io_en), .bar_base(bar_base)
    );

    pci_tgt_par u_par (
        .clk(clk), .rst_n(rst_n), .drive(ad_oe), .ad(ad_out),
        .cbe_n(cbe_n), .par_out(par_out), .par_oe(par_oe)
    );

    assign ad_out    = cur_cfg ? cfg_rdata : lcl_rdata;
    assign lcl_sel   = (data_ph && !cur_cfg) ? cur_win : '0;
    assign lcl_be    = ~cbe_n;
    assign lcl_wdata = ad_in;
    assign lcl_wr    = xfer && !cur_cfg && cur_wr;
    assign lcl_rd    = xfer && !cur_cfg && !cur_wr;

    a_r8_strobe_needs_irdy: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_wr || lcl_rd) |-> (!irdy_n && !trdy_n));

    a_r2_ready_inside_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    a_r5_mem_never_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && cbe_n[3:1] == 3'b011) |=> devsel_n);

    a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lcl_sel));

endmodule

// File: tb/pci_io_target_test.sv
module pci_io_target_test;
    localparam logic [15:0] VEN  = 16'h1E0F;
    localparam logic [15:0] DEV  = 16'h0210;
    localparam logic [15:0] SVID = 16'h1E0F;
    localparam logic [15:0] SID  = 16'h0042;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out, lcl_wdata, lcl_rdata;
    logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, lcl_wr, lcl_rd;
    logic [1:0]  lcl_sel;
    logic [2:0]  lcl_addr;
    logic [3:0]  lcl_be;

    always #5 clk = ~clk;

    assign lcl_rdata = 32'hC0DE0000 | {22'd0, lcl_sel, 5'd0, lcl_addr};

    pci_io_target #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .SUBSYS_VID(SVID),
                    .SUBSYS_ID(SID)) uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .lcl_sel(lcl_sel),
        .lcl_addr(lcl_addr), .lcl_be(lcl_be), .lcl_wdata(lcl_wdata),
        .lcl_wr(lcl_wr), .lcl_rd(lcl_rd), .lcl_rdata(lcl_rdata)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // behavioural model state
    bit          m_dev_n = 1, m_trdy_n = 1, m_adoe = 0, m_lwr = 0, m_lrd = 0;
    logic [31:0] m_ad = '0;
    string       m_req = "R1";
    bit          prev_adoe = 0;
    logic [35:0] prev_bits = '0;
    bit          m_io = 0;
    logic [31:0] m_bar [2] = '{32'd0, 32'd0};
    logic [7:0]  m_intl = 8'h00;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check(devsel_n === m_dev_n, m_req, "devsel_n", 32'(devsel_n), 32'(m_dev_n));
            check(trdy_n === m_trdy_n, m_req, "trdy_n", 32'(trdy_n), 32'(m_trdy_n));
            check(ad_oe === m_adoe, m_req, "ad_oe", 32'(ad_oe), 32'(m_adoe));
            check(lcl_wr === m_lwr, m_req, "lcl_wr", 32'(lcl_wr), 32'(m_lwr));
            check(lcl_rd === m_lrd, m_req, "lcl_rd", 32'(lcl_rd), 32'(m_lrd));
            check(par_oe === prev_adoe, "R11", "par_oe", 32'(par_oe), 32'(prev_adoe));
            if (prev_adoe)
                check(par_out === ^prev_bits, "R11", "par_out", 32'(par_out), 32'(^prev_bits));
            if (m_adoe)
                check(ad_out === m_ad, m_req, "ad_out", ad_out, m_ad);
            prev_adoe = m_adoe;
            prev_bits = {m_ad, cbe_n};
        end
    end

    function automatic logic [31:0] cfg_model(input logic [31:0] a);
        case (a[7:2])
            6'd0:  return {DEV, VEN};
            6'd1:  return {31'd0, m_io};
            6'd2:  return {24'h070102, 8'h01};
            6'd4:  return m_bar[0] | 32'd1;
            6'd5:  return m_bar[1] | 32'd1;
            6'd11: return {SID, SVID};
            6'd15: return {16'h0, 8'h01, m_intl};
            default: return 32'd0;
        endcase
    endfunction

    function automatic int win_of(input logic [31:0] a);
        if (m_io && a[31:3] == m_bar[0][31:3]) return 0;
        if (m_io && a[31:3] == m_bar[1][31:3]) return 1;
        return -1;
    endfunction

    task automatic cfg_model_write(input logic [31:0] a, input logic [31:0] d,
                                   input logic [3:0] be_n);
        int idx = int'(a[7:2]);
        if (idx == 1 && !be_n[0]) m_io = d[0];
        if (idx == 15 && !be_n[0]) m_intl = d[7:0];
        if (idx == 4 || idx == 5) begin
            logic [31:0] v = m_bar[idx-4];
            for (int b = 0; b < 4; b++) if (!be_n[b]) v[8*b +: 8] = d[8*b +: 8];
            m_bar[idx-4] = v & 32'hFFFF_FFF8;
        end
    endtask

    task automatic idle_model();
        m_dev_n = 1; m_trdy_n = 1; m_adoe = 0; m_lwr = 0; m_lrd = 0;
    endtask

    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input bit id,
                        input int n, input bit stall, input bit claim,
                        input logic [3:0] be_n, input logic [31:0] wd0,
                        input logic [31:0] wd1, input string rq);
        bit rd  = !cmd[0];
        bit cfg = cmd[3];
        @(posedge clk); #1;
        frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd; idsel = id;
        m_req = rq; idle_model();
        for (int k = 0; k < n; k++) begin
            logic [31:0] a  = addr + 32'(4 * k);
            logic [31:0] wd = (k == 0) ? wd0 : wd1;
            int          w  = cfg ? -1 : win_of(a);
            logic [31:0] ex = cfg ? cfg_model(a)
                                  : (32'hC0DE0000 | {22'd0, 2'(1 << ((w < 0) ? 0 : w)), 5'd0, a[2:0]});
            if (stall && k == 0) begin
                @(posedge clk); #1;
                irdy_n = 1; idsel = 0; ad_in = 32'h0; cbe_n = be_n;
                m_dev_n = !claim; m_trdy_n = !claim; m_adoe = claim && rd;
                m_ad = ex; m_lwr = 0; m_lrd = 0;
            end
            @(posedge clk); #1;
            irdy_n = 0; frame_n = (k == n - 1); cbe_n = be_n; idsel = 0;
            ad_in = rd ? 32'h0 : wd;
            m_dev_n = !claim; m_trdy_n = !claim; m_adoe = claim && rd; m_ad = ex;
            m_lwr = claim && !cfg && !rd; m_lrd = claim && !cfg && rd;
            @(negedge clk);
            if (claim && !cfg) begin
                check(lcl_sel === 2'(1 << w), "R6", "lcl_sel", 32'(lcl_sel), 32'(1 << w));
                check(lcl_addr === a[2:0], "R9", "lcl_addr", 32'(lcl_addr), 32'(a[2:0]));
                if (!rd) begin
                    check(lcl_wdata === wd, "R6", "lcl_wdata", lcl_wdata, wd);
                    check(lcl_be === ~be_n, "R6", "lcl_be", 32'(lcl_be), 32'(~be_n));
                end
            end else begin
                check(lcl_sel === 2'b00, rq, "lcl_sel idle", 32'(lcl_sel), 32'd0);
            end
            if (claim && cfg && !rd) cfg_model_write(a, wd, be_n);
        end
        @(posedge clk); #1;
        frame_n = 1; irdy_n = 1; ad_in = 32'h0; cbe_n = 4'hF;
        m_req = "R10"; idle_model();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(lcl_sel === 2'b00, "R1", "lcl_sel", 32'(lcl_sel), 32'd0);
        // identity and class words
        xact(4'b1010, 32'h00, 1, 1, 0, 1, 4'h0, 0, 0, "R2");
        xact(4'b1010, 32'h08, 1, 1, 1, 1, 4'h0, 0, 0, "R8");
        xact(4'b1010, 32'h00, 1, 2, 0, 1, 4'h0, 0, 0, "R9");
        xact(4'b1010, 32'h2C, 1, 1, 0, 1, 4'h0, 0, 0, "R2");
        xact(4'b1010, 32'h3C, 1, 1, 0, 1, 4'h0, 0, 0, "R2");
        // not selected
        xact(4'b1010, 32'h00, 0, 1, 0, 0, 4'h0, 0, 0, "R3");
        xact(4'b1010, 32'h100, 1, 1, 0, 0, 4'h0, 0, 0, "R3");
        // reserved dwords
        xact(4'b1010, 32'h18, 1, 1, 0, 1, 4'h0, 0, 0, "R13");
        xact(4'b1010, 32'h0C, 1, 1, 0, 1, 4'h0, 0, 0, "R13");
        // base register sizing
        xact(4'b1011, 32'h10, 1, 1, 0, 1, 4'h0, 32'hFFFF_FFFF, 0, "R4");
        xact(4'b1010, 32'h10, 1, 1, 0, 1, 4'h0, 0, 0, "R4");
        xact(4'b1011, 32'h10, 1, 2, 1, 1, 4'h0, 32'h0000_0300, 32'h0000_040F, "R4");
        xact(4'b1010, 32'h10, 1, 2, 0, 1, 4'h0, 0, 0, "R4");
        // I/O disabled: not claimed
        xact(4'b0011, 32'h300, 0, 1, 0, 0, 4'h0, 32'h1111_2222, 0, "R5");
        xact(4'b1011, 32'h04, 1, 1, 0, 1, 4'h0, 32'h0000_0001, 0, "R5");
        xact(4'b1010, 32'h04, 1, 1, 0, 1, 4'h0, 0, 0, "R5");
        xact(4'b0111, 32'h300, 0, 1, 0, 0, 4'h0, 32'h3333_4444, 0, "R5");
        xact(4'b0110, 32'h408, 0, 1, 0, 0, 4'h0, 0, 0, "R5");
        // I/O traffic
        xact(4'b0011, 32'h300, 0, 2, 1, 1, 4'b0101, 32'hAABB_CCDD, 32'h1234_5678, "R6");
        xact(4'b0010, 32'h408, 0, 1, 1, 1, 4'h0, 0, 0, "R7");
        xact(4'b0010, 32'h304, 0, 1, 0, 1, 4'b0011, 0, 0, "R7");
        xact(4'b0011, 32'h40C, 0, 1, 0, 1, 4'h0, 32'h0F0F_0F0F, 0, "R6");
        xact(4'b0010, 32'h500, 0, 1, 0, 0, 4'h0, 0, 0, "R5");
        // byte-masked header writes
        xact(4'b1011, 32'h3C, 1, 1, 0, 1, 4'b1110, 32'hFFFF_FF0B, 0, "R12");
        xact(4'b1010, 32'h3C, 1, 1, 0, 1, 4'h0, 0, 0, "R12");
        xact(4'b1011, 32'h04, 1, 1, 0, 1, 4'hF, 32'h0, 0, "R12");
        xact(4'b1010, 32'h04, 1, 1, 0, 1, 4'h0, 0, 0, "R12");
        xact(4'b1011, 32'h14, 1, 1, 0, 1, 4'b1101, 32'h0000_0700, 0, "R12");
        xact(4'b1010, 32'h14, 1, 1, 0, 1, 4'h0, 0, 0, "R12");
        repeat (2) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule